// File: doc/BRIEF.md
# DCC Track Waveform Generator with Feedback Cutout

This block turns short command packets into the bipolar-timing bit stream of a model-railway DCC track. A free-running tick of 58 us paces a bit-phase machine. Each packet goes out as a run of preamble one-bits, then every byte behind a zero separator, then a single one end bit. A one-bit is one tick high and one tick low. A zero-bit is two ticks of each. When no packet is waiting and no repeats remain, the block fills the line with a fixed idle packet. On the programming track, or in debug mode, it uses an all-zero reset packet instead.

A single-entry pending slot takes the next packet from a load strobe. The slot moves into the transmit buffer while the second-to-last preamble bit is being sent. A short reminder window is signalled just before that hand-over, so a host can slip in a low-priority packet late. On the main track, with the cutout enabled when a packet ends, a brake output goes active partway into the next preamble. It stays active for a feedback window and is released at a fixed preamble count.

Top module: `dcc_track_gen`

## Requirements
- R1: Out of reset track_o is low, brake_o is low, ready_o is high and remind_win_o is low.
- R2: A one-bit holds track_o high for TICK_CYC cycles, then low for TICK_CYC cycles. A zero-bit holds it high for 2*TICK_CYC cycles, then low for 2*TICK_CYC cycles.
- R3: A frame is PREAMBLE one-bits, then for each byte a zero separator followed by its 8 bits MSB first, then a single one end bit. The next preamble follows at once.
- R4: With nothing pending and no repeats left, the filler packet is used. On the main track with debug off it is bytes FF 00 FF. On the programming track, or on the main track with debug on, it is 00 00 00.
- R5: A loaded packet sends byte k from ld_bytes_i[8k+7:8k] as its k-th byte, with 1 to MAX_BYTES bytes. It goes out 1+ld_rep_i times in a row before anything else.
- R6: A load is taken only when ready_o is high and ld_len_i is between 1 and MAX_BYTES; ready_o then drops on the next cycle. A load with ready_o low, or with a bad length, leaves the stream unchanged.
- R7: remind_win_o is high only while no repeats remain and the remaining-preamble count is 3 or 2. That is exactly two preamble bits (4*TICK_CYC cycles) before promotion.
- R8: On the main track with cut_en_i high when the end bit starts, brake_o rises exactly CUT_CYC cycles after the rising edge of the end bit.
- R9: brake_o falls at the rising edge of the preamble bit that leaves 10 preamble bits to send. That edge is 2*(PREAMBLE-10)*TICK_CYC cycles after the end bit rises.
- R10: brake_o never rises after an end bit sent with cut_en_i low or on the programming track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_trk_i | input | 1 | 1 = main track, 0 = programming track |
| cut_en_i | input | 1 | Feedback cutout enable |
| dbg_i | input | 1 | Debug filler select (reset packets on main) |
| ld_valid_i | input | 1 | Packet load strobe |
| ld_bytes_i | input | 48 | Packet bytes, byte k at [8k+7:8k] |
| ld_len_i | input | 3 | Packet length in bytes, 1 to 6 |
| ld_rep_i | input | 4 | Extra repeats after the first send |
| track_o | output | 1 | Track signal |
| brake_o | output | 1 | Cutout brake drive |
| ready_o | output | 1 | Pending slot free, next packet requested |
| remind_win_o | output | 1 | Late reminder-insertion window |

## Verification
On every cycle, the embedded assertions check four things. The track line only moves right after a tick. The reminder window only opens right after a bit decision. A refused load leaves the pending slot untouched. The brake never rises without a cutout armed on the main track, and it drops at once on release.

Only the bench scenarios can show the rest, by decoding the line back into bits and bytes. That covers frame layout, filler choice per track and debug mode, repeat counts and minimum/maximum lengths. It also covers the exact cycle offsets of the brake edges from the end bit.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    BP_START     = 3'd0,
    BP_MID_ONE   = 3'd1,
    BP_HIGH_ZERO = 3'd2,
    BP_MID_ZERO  = 3'd3,
    BP_LOW_ZERO  = 3'd4,
    BP_UNKNOWN   = 3'd5
  } bit_phase_e;

  typedef enum logic [1:0] {
    SQ_PRE  = 2'd0,
    SQ_DATA = 2'd1,
    SQ_END  = 2'd2
  } seq_phase_e;
endpackage

// File: rtl/dcc_tick_gen.sv
module dcc_tick_gen #(
  parameter int unsigned PERIOD = 58
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(PERIOD - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dcc_bit_fsm.sv
module dcc_bit_fsm
  import dcc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic nxt_bit,
  output logic bit_req,
  output logic track
);
  bit_phase_e st_q, st_d;
  logic       trk_q, trk_d;

  assign bit_req = tick && (st_q == BP_START || st_q == BP_UNKNOWN);
  assign track   = trk_q;

  always_comb begin
    st_d  = st_q;
    trk_d = trk_q;
    if (tick) begin
      case (st_q)
        BP_START, BP_UNKNOWN: begin
          trk_d = 1'b1;
          st_d  = nxt_bit ? BP_MID_ONE : BP_HIGH_ZERO;
        end
        BP_MID_ONE:   begin trk_d = 1'b0; st_d = BP_START;    end
        BP_HIGH_ZERO: begin trk_d = 1'b1; st_d = BP_MID_ZERO; end
        BP_MID_ZERO:  begin trk_d = 1'b0; st_d = BP_LOW_ZERO; end
        BP_LOW_ZERO:  begin trk_d = 1'b0; st_d = BP_START;    end
        default:      begin trk_d = 1'b0; st_d = BP_UNKNOWN;  end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BP_UNKNOWN;
      trk_q <= 1'b0;
    end else if (tick) begin
      st_q  <= st_d;
      trk_q <= trk_d;
    end
  end

  // R2
  track_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(track));
endmodule

// File: rtl/dcc_pkt_seq.sv
module dcc_pkt_seq
  import dcc_pkg::*;
#(
  parameter int unsigned PRE   = 16,
  parameter int unsigned NB    = 6,
  parameter int unsigned REP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_req,
  input  logic              main_i,
  input  logic              dbg_i,
  input  logic              cut_en_i,
  input  logic              ld_valid_i,
  input  logic [NB*8-1:0]   ld_bytes_i,
  input  logic [$clog2(NB+1)-1:0] ld_len_i,
  input  logic [REP_W-1:0]  ld_rep_i,
  output logic              nxt_bit,
  output logic              ready_o,
  output logic              window_o,
  output logic              arm_o,
  output logic              release_o,
  output logic              cut_ok_o
);
  localparam int unsigned PW = $clog2(PRE + 1);
  localparam int unsigned LW = $clog2(NB + 1);

  seq_phase_e             ph_q, ph_d;
  logic [PW-1:0]          rem_q, rem_d, rem_dec;
  logic [LW-1:0]          byte_q, byte_d, txlen_q, txlen_d, plen_q, plen_d;
  logic [3:0]             pos_q, pos_d;
  logic [NB-1:0][7:0]     tx_q, tx_d, pend_q, pend_d;
  logic [REP_W-1:0]       rep_q, rep_d, prep_q, prep_d;
  logic                   pvld_q, pvld_d, cut_q, cut_d, promote, take;

  assign rem_dec   = rem_q - PW'(1);
  assign ready_o   = !pvld_q;
  assign window_o  = (ph_q == SQ_PRE) && (rep_q == '0) && (rem_q < PW'(4)) && (rem_q > PW'(1));
  assign promote   = bit_req && (ph_q == SQ_PRE) && (rem_dec == PW'(1));
  assign release_o = bit_req && (ph_q == SQ_PRE) && (rem_dec == PW'(10));
  assign arm_o     = bit_req && (ph_q == SQ_END) && main_i && cut_en_i;
  assign cut_ok_o  = cut_q;
  assign take      = ld_valid_i && !pvld_q && (ld_len_i != '0) && (ld_len_i <= LW'(NB));

  always_comb begin
    case (ph_q)
      SQ_DATA: nxt_bit = (pos_q == 4'd8) ? 1'b0 : tx_q[byte_q][pos_q[2:0]];
      default: nxt_bit = 1'b1;
    endcase
  end

  always_comb begin
    ph_d = ph_q; rem_d = rem_q; byte_d = byte_q; pos_d = pos_q; cut_d = cut_q;
    tx_d = tx_q; txlen_d = txlen_q; rep_d = rep_q;
    pend_d = pend_q; plen_d = plen_q; prep_d = prep_q; pvld_d = pvld_q;
    if (bit_req) begin
      case (ph_q)
        SQ_PRE: begin
          rem_d = rem_dec;
          if (rem_dec == '0) begin
            ph_d = SQ_DATA; byte_d = '0; pos_d = 4'd8;
          end
        end
        SQ_DATA: begin
          if (pos_q == 4'd8) pos_d = 4'd7;
          else if (pos_q != 4'd0) pos_d = pos_q - 4'd1;
          else if (byte_q == txlen_q - LW'(1)) ph_d = SQ_END;
          else begin byte_d = byte_q + LW'(1); pos_d = 4'd8; end
        end
        default: begin
          ph_d  = SQ_PRE;
          rem_d = PW'(PRE);
          cut_d = main_i && cut_en_i;
        end
      endcase
    end
    if (promote) begin
      if (rep_q != '0) rep_d = rep_q - REP_W'(1);
      else if (pvld_q) begin
        tx_d = pend_q; txlen_d = plen_q; rep_d = prep_q; pvld_d = 1'b0;
      end else begin
        for (int k = 0; k < int'(NB); k++) tx_d[k] = 8'h00;
        if (main_i && !dbg_i) begin tx_d[0] = 8'hFF; tx_d[2] = 8'hFF; end
        txlen_d = LW'(3); rep_d = '0;
      end
    end
    if (take) begin
      pend_d = ld_bytes_i; plen_d = ld_len_i; prep_d = ld_rep_i; pvld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= SQ_PRE; rem_q <= PW'(PRE); byte_q <= '0; pos_q <= 4'd8; cut_q <= 1'b0;
      tx_q <= '0; txlen_q <= LW'(3); rep_q <= '0;
      pend_q <= '0; plen_q <= LW'(1); prep_q <= '0; pvld_q <= 1'b0;
    end else begin
      ph_q <= ph_d; rem_q <= rem_d; byte_q <= byte_d; pos_q <= pos_d; cut_q <= cut_d;
      tx_q <= tx_d; txlen_q <= txlen_d; rep_q <= rep_d;
      pend_q <= pend_d; plen_q <= plen_d; prep_q <= prep_d; pvld_q <= pvld_d;
    end
  end

  // R6
  refused_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && pvld_q) |=> $stable(pend_q));
  // R7
  window_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(window_o) |-> $past(bit_req));
  // R5
  byte_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == SQ_DATA) |-> (byte_q < txlen_q));
endmodule

// File: rtl/dcc_cutout.sv
module dcc_cutout #(
  parameter int unsigned DLY = 145
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic release_i,
  output logic brake
);
  localparam int unsigned CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d, brk_q, brk_d;

  assign brake = brk_q;

  always_comb begin
    cnt_d = cnt_q; run_d = run_q; brk_d = brk_q;
    if (arm) begin
      cnt_d = '0; run_d = 1'b1;
    end else if (release_i) begin
      run_d = 1'b0; brk_d = 1'b0;
    end else if (run_q) begin
      if (cnt_q == CW'(DLY - 1)) begin
        run_d = 1'b0; brk_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; run_q <= 1'b0; brk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; run_q <= run_d; brk_q <= brk_d;
    end
  end

  // R9
  release_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && !arm) |=> !brake);
endmodule

// File: rtl/dcc_track_gen.sv
module dcc_track_gen #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned TICK_US   = 58,
  parameter int unsigned CUT_US    = 145,
  parameter int unsigned PREAMBLE  = 16,
  parameter int unsigned MAX_BYTES = 6,
  parameter int unsigned REP_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   main_trk_i,
  input  logic                   cut_en_i,
  input  logic                   dbg_i,
  input  logic                   ld_valid_i,
  input  logic [MAX_BYTES*8-1:0] ld_bytes_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0] ld_len_i,
  input  logic [REP_W-1:0]       ld_rep_i,
  output logic                   track_o,
  output logic                   brake_o,
  output logic                   ready_o,
  output logic                   remind_win_o
);
  localparam int unsigned CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int unsigned TICK_CYC   = CYC_PER_US * TICK_US;
  localparam int unsigned CUT_CYC    = CYC_PER_US * CUT_US;

  logic [1:0] rst_sync_q;
  logic       rst_n_s, tick, bit_req, nxt_bit, arm, rel, cut_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dcc_tick_gen #(.PERIOD(TICK_CYC)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .tick(tick));

  dcc_bit_fsm u_bits (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .nxt_bit(nxt_bit),
    .bit_req(bit_req), .track(track_o));

  dcc_pkt_seq #(.PRE(PREAMBLE), .NB(MAX_BYTES), .REP_W(REP_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .bit_req(bit_req), .main_i(main_trk_i),
    .dbg_i(dbg_i), .cut_en_i(cut_en_i), .ld_valid_i(ld_valid_i),
    .ld_bytes_i(ld_bytes_i), .ld_len_i(ld_len_i), .ld_rep_i(ld_rep_i),
    .nxt_bit(nxt_bit), .ready_o(ready_o), .window_o(remind_win_o),
    .arm_o(arm), .release_o(rel), .cut_ok_o(cut_ok));

  dcc_cutout #(.DLY(CUT_CYC)) u_cut (
    .clk(clk), .rst_n(rst_n_s), .arm(arm), .release_i(rel), .brake(brake_o));

  // R10
  brake_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(brake_o) |-> cut_ok);
endmodule

// File: tb/dcc_track_gen_tb.sv
module dcc_track_gen_tb;
  localparam int TICK = 58;
  localparam int CUT  = 145;
  localparam int PRE  = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic main_trk = 1'b1, cut_en = 1'b0, dbg = 1'b0, ld_valid = 1'b0;
  logic [47:0] ld_bytes = '0;
  logic [2:0]  ld_len = 3'd1;
  logic [3:0]  ld_rep = '0;
  logic track_o, brake_o, ready_o, win_o;

  always #5 clk = ~clk;

  dcc_track_gen #(.CLK_HZ(1_000_000)) u_dut (
    .clk(clk), .rst_n(rst_n), .main_trk_i(main_trk), .cut_en_i(cut_en), .dbg_i(dbg),
    .ld_valid_i(ld_valid), .ld_bytes_i(ld_bytes), .ld_len_i(ld_len), .ld_rep_i(ld_rep),
    .track_o(track_o), .brake_o(brake_o), .ready_o(ready_o), .remind_win_o(win_o));

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic bits [0:4095];
  int   btime [0:4095];
  int   nbits, rd, rise_t, fall_t, last_hi, have_fall, timing_bad;
  logic trk_p, brk_p, win_p;
  int   brk_rises, brk_rise_t, brk_fall_t, brk_falls, win_rises, win_bad, win_t;
  logic [7:0] pk [0:7];
  int   pk_len, pk_pre, pk_end;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      nbits = 0; have_fall = 0; timing_bad = 0; trk_p = 0; brk_p = 0; win_p = 0;
      brk_rises = 0; brk_falls = 0; win_rises = 0; win_bad = 0;
    end else begin
      if (track_o && !trk_p) begin
        if (have_fall != 0 && (cyc - fall_t) != last_hi) timing_bad++;
        rise_t = cyc;
      end
      if (!track_o && trk_p) begin
        last_hi = cyc - rise_t;
        if (last_hi != TICK && last_hi != 2*TICK) timing_bad++;
        if (nbits < 4096) begin
          bits[nbits] = (last_hi == TICK); btime[nbits] = rise_t; nbits++;
        end
        fall_t = cyc; have_fall = 1;
      end
      if (brake_o && !brk_p) begin brk_rises++; brk_rise_t = cyc; end
      if (!brake_o && brk_p) begin brk_falls++; brk_fall_t = cyc; end
      if (win_o && !win_p) begin win_rises++; win_t = cyc; end
      if (!win_o && win_p && (cyc - win_t) != 4*TICK) win_bad++;
      trk_p = track_o; brk_p = brake_o; win_p = win_o;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic c, input logic d);
    @(negedge clk);
    rst_n = 1'b0; main_trk = m; cut_en = c; dbg = d; ld_valid = 1'b0;
    repeat (3) @(negedge clk);
    rd = 0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic next_bit(output logic b, output int t);
    while (rd >= nbits) @(negedge clk);
    b = bits[rd]; t = btime[rd]; rd++;
  endtask

  task automatic get_pkt();
    logic b; int t; logic [7:0] v;
    pk_pre = 0; pk_len = 0;
    next_bit(b, t);
    while (b) begin pk_pre++; next_bit(b, t); end
    do begin
      v = '0;
      for (int i = 0; i < 8; i++) begin next_bit(b, t); v = {v[6:0], b}; end
      if (pk_len < 8) pk[pk_len] = v;
      pk_len++;
      next_bit(b, t);
    end while (!b);
    pk_end = t;
  endtask

  task automatic expect_pkt(input string req, input logic [47:0] e, input int elen);
    logic [47:0] got;
    get_pkt();
    got = '0;
    for (int k = 0; k < 6; k++) if (k < pk_len) got[8*k +: 8] = pk[k];
    chk(pk_len == elen, req, pk_len, elen);
    chk(got == e, req, int'(got[31:0]), int'(e[31:0]));
  endtask

  task automatic load(input logic [47:0] b, input logic [2:0] l, input logic [3:0] r);
    @(negedge clk);
    ld_valid = 1'b1; ld_bytes = b; ld_len = l; ld_rep = r;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b1, 1'b0);
    // R1
    chk(track_o == 1'b0, "R1 track", track_o, 0);
    chk(brake_o == 1'b0, "R1 brake", brake_o, 0);
    chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
    chk(win_o == 1'b0,   "R1 window", win_o, 0);
  endtask

  task automatic t_idle_main();
    do_reset(1'b1, 1'b0, 1'b0);
    expect_pkt("R4 idle main", 48'h00_00_00_FF_00_FF, 3);
    chk(pk_pre == PRE, "R3 preamble", pk_pre, PRE);
    expect_pkt("R3 second frame", 48'h00_00_00_FF_00_FF, 3);
    chk(pk_pre == PRE, "R3 preamble 2", pk_pre, PRE);
    chk(timing_bad == 0, "R2 bit timing", timing_bad, 0);
    chk(win_rises >= 1 && win_bad == 0, "R7 window length", win_bad, 0);
  endtask

  task automatic t_prog();
    do_reset(1'b0, 1'b1, 1'b0);
    expect_pkt("R4 reset on prog", 48'h0, 3);
    repeat (TICK*4) @(negedge clk);
    chk(brk_rises == 0, "R10 prog no brake", brk_rises, 0);
  endtask

  task automatic t_debug();
    do_reset(1'b1, 1'b0, 1'b1);
    expect_pkt("R4 debug main", 48'h0, 3);
  endtask

  task automatic t_repeat();
    do_reset(1'b1, 1'b0, 1'b0);
    load(48'h00_00_00_99_3C_A5, 3'd3, 4'd2);
    for (int i = 0; i < 3; i++) expect_pkt("R5 repeat copy", 48'h00_00_00_99_3C_A5, 3);
    expect_pkt("R5 idle after repeats", 48'h00_00_00_FF_00_FF, 3);
    // R7: open in preamble 1 and 4 only, closed while repeats remain
    chk(win_rises == 2, "R7 window closed during repeats", win_rises, 2);
    chk(win_bad == 0, "R7 window duration", win_bad, 0);
  endtask

  task automatic t_lengths();
    do_reset(1'b1, 1'b0, 1'b0);
    load(48'h0F_1E_2D_3C_4B_5A, 3'd6, 4'd0);
    expect_pkt("R5 max length", 48'h0F_1E_2D_3C_4B_5A, 6);
    while (!ready_o) @(negedge clk);
    load(48'h00_00_00_00_00_81, 3'd1, 4'd0);
    expect_pkt("R5 min length", 48'h00_00_00_00_00_81, 1);
  endtask

  task automatic t_refuse();
    do_reset(1'b1, 1'b0, 1'b0);
    load(48'h0, 3'd0, 4'd0);
    chk(ready_o == 1'b1, "R6 bad length refused", ready_o, 1);
    load(48'h00_00_00_00_C3_11, 3'd2, 4'd0);
    chk(ready_o == 1'b0, "R6 ready drops", ready_o, 0);
    load(48'h00_00_00_00_77_66, 3'd2, 4'd0);
    expect_pkt("R6 first load kept", 48'h00_00_00_00_C3_11, 2);
    expect_pkt("R6 refused load absent", 48'h00_00_00_FF_00_FF, 3);
  endtask

  task automatic t_cutout();
    do_reset(1'b1, 1'b1, 1'b0);
    get_pkt();
    while (brk_falls == 0) @(negedge clk);
    chk(brk_rises == 1, "R8 one brake pulse", brk_rises, 1);
    chk(brk_rise_t - pk_end == CUT, "R8 brake rise offset", brk_rise_t - pk_end, CUT);
    chk(brk_fall_t - pk_end == 2*(PRE-10)*TICK, "R9 brake fall offset",
        brk_fall_t - pk_end, 2*(PRE-10)*TICK);
  endtask

  task automatic t_cut_off();
    do_reset(1'b1, 1'b0, 1'b0);
    get_pkt();
    get_pkt();
    chk(brk_rises == 0, "R10 disabled no brake", brk_rises, 0);
  endtask

  initial begin
    t_reset();
    t_idle_main();
    t_prog();
    t_debug();
    t_repeat();
    t_lengths();
    t_refuse();
    t_cutout();
    t_cut_off();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    while (cyc < 190_000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule